// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block gives two independently clocked ports a side channel for single words that bypasses the FIFO data path. Each port has an enable, a read/write direction and a mailbox-select input. With the select high, the port's access goes to a mailbox register. With the select low, the access is decoded into a FIFO read or FIFO write strobe for the queue logic next to this block. Port A writes the first mailbox and port B reads it. Port B writes the second mailbox and port A reads it.

Each mailbox has an active-low "holds a word" flag in its writer's clock domain. A write drops the flag and locks the mailbox, so later writes are refused. Once the word has crossed into the reader's domain, a mailbox read there sends one release event back, and that event raises the flag again. Both directions of the handshake cross the clock boundary as toggles through multi-stage synchronizers. Each access therefore produces exactly one event on the far side. Port B's read data comes from an output multiplexer that selects the first mailbox or the FIFO output register.

Top module: `mailbox_pair`

## Requirements
- R1: Per port, with the enable high and the mailbox select low, the write direction (write=1) raises the FIFO write strobe and the read direction (write=0) raises the FIFO read strobe, combinationally. With the mailbox select high, or the enable low, both FIFO strobes stay low.
- R2: A port-A mailbox write on a clk_a edge while `a_mb1_full_n` is high stores `a_wdata` in mailbox 1 and drives `a_mb1_full_n` low from that edge on.
- R3: While `a_mb1_full_n` is low, port-A mailbox writes are ignored: mailbox 1 keeps its word, as seen on `b_rdata` with `b_mbox` high, and the flag stays low.
- R4: A port-B mailbox read made at least 6 clk_b cycles after the mailbox 1 write raises `a_mb1_full_n` within 10 clk_a cycles. A port-B mailbox read made while no unread word is pending has no effect, so a later write's flag is not raised by it.
- R5: Mailbox 2 mirrors mailbox 1 with the ports swapped: a port-B write with `b_mb2_full_n` high stores `b_wdata` and drives the flag low, further port-B writes are ignored while the flag is low, `a_rdata` shows the stored word, and a port-A mailbox read raises the flag again.
- R6: Reset (rst_n low) drives both flags high and clears both mailboxes to zero.
- R7: `b_rdata` shows mailbox 1 when `b_mbox` is high and `fifo_rdata` when `b_mbox` is low. `a_rdata` always shows mailbox 2.
- R8: When a release reaches the writer's domain in the same cycle as a held write request, the read completes first and that write is refused. The flag is then high for exactly one writer cycle, and the word accepted is the one presented at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_en | input | 1 | Port A access enable |
| a_write | input | 1 | Port A direction, 1 = write |
| a_mbox | input | 1 | Port A mailbox select |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Mailbox 2 contents for port A |
| a_fifo_wr | output | 1 | Port A FIFO write strobe |
| a_fifo_rd | output | 1 | Port A FIFO read strobe |
| a_mb1_full_n | output | 1 | Mailbox 1 flag, low while a word is held (clk_a domain) |
| b_en | input | 1 | Port B access enable |
| b_write | input | 1 | Port B direction, 1 = write |
| b_mbox | input | 1 | Port B mailbox select |
| b_wdata | input | DATA_W | Port B write data |
| fifo_rdata | input | DATA_W | FIFO output register contents |
| b_rdata | output | DATA_W | Port B read data (mailbox 1 or FIFO) |
| b_fifo_wr | output | 1 | Port B FIFO write strobe |
| b_fifo_rd | output | 1 | Port B FIFO read strobe |
| b_mb2_full_n | output | 1 | Mailbox 2 flag, low while a word is held (clk_b domain) |

## Verification
The hardest case to reach is a release that lands in the writer's domain on the very edge where a new write is attempted. With unrelated clocks, that edge cannot be chosen from outside. The bench holds a port-A mailbox write asserted on every clk_a cycle with fresh data each cycle, while port B performs one read. Whichever edge the release reaches, the flag must read high for exactly one clk_a cycle. The word later read on port B must be the one presented during that cycle. A stale-release case is also built: port B reads an empty mailbox, a new word is then written, and the bench waits long enough to prove the flag stays low.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Decoded intent of one port access in one cycle.
  typedef struct packed {
    logic mbx_wr;
    logic mbx_rd;
    logic fifo_wr;
    logic fifo_rd;
  } port_op_t;

  // Split an access into mailbox or FIFO strobes.
  function automatic port_op_t decode_op(input logic en, input logic wr, input logic mbx);
    port_op_t op;
    op.mbx_wr  = en &  mbx &  wr;
    op.mbx_rd  = en &  mbx & ~wr;
    op.fifo_wr = en & ~mbx &  wr;
    op.fifo_rd = en & ~mbx & ~wr;
    return op;
  endfunction

  // One toggle edge = one crossed event.
  function automatic logic toggle_seen(input logic now_v, input logic last_v);
    return now_v ^ last_v;
  endfunction

  // Flag update order: an accepted write wins, else a release sets the flag.
  function automatic logic next_flag_n(input logic cur_n, input logic wr_ok, input logic rel);
    if (wr_ok) return 1'b0;
    if (rel)   return 1'b1;
    return cur_n;
  endfunction

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
  import mbox_pkg::*;
(
  input  logic     en,
  input  logic     wr,
  input  logic     mbx,
  output port_op_t op
);

  always_comb op = decode_op(en, wr, mbx);

endmodule

// File: rtl/mbox_toggle_sync.sv
module mbox_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_d,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  import mbox_pkg::*;

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          seen_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("mbox_toggle_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk_d or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[LAST-1:0], tog_in};
      seen_q  <= chain_q[LAST];
    end
  end

  assign pulse = toggle_seen(chain_q[LAST], seen_q);

endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_w,
  input  logic              clk_r,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_req,
  output logic              full_n,
  output logic [DATA_W-1:0] data,
  output logic              wr_acc,
  output logic              rel_pulse
);
  import mbox_pkg::*;

  logic              full_n_q;
  logic [DATA_W-1:0] data_q;
  logic              wtog_q;
  logic              rtog_q;
  logic              pend_q;
  logic              arr_pulse;
  logic              rd_acc;

  // ---------------- writer domain ----------------
  assign wr_acc = wr_req & full_n_q;

  always_ff @(posedge clk_w or negedge rst_n) begin
    if (!rst_n) begin
      full_n_q <= 1'b1;
      data_q   <= '0;
      wtog_q   <= 1'b0;
    end else begin
      full_n_q <= next_flag_n(full_n_q, wr_acc, rel_pulse);
      if (wr_acc) begin
        data_q <= wdata;
        wtog_q <= ~wtog_q;
      end
    end
  end

  mbox_toggle_sync #(.STAGES(SYNC_STAGES)) u_rel_sync (
    .clk_d (clk_w),
    .rst_n (rst_n),
    .tog_in(rtog_q),
    .pulse (rel_pulse)
  );

  // ---------------- reader domain ----------------
  mbox_toggle_sync #(.STAGES(SYNC_STAGES)) u_arr_sync (
    .clk_d (clk_r),
    .rst_n (rst_n),
    .tog_in(wtog_q),
    .pulse (arr_pulse)
  );

  assign rd_acc = rd_req & pend_q;

  always_ff @(posedge clk_r or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rtog_q <= 1'b0;
    end else begin
      if (rd_acc) begin
        pend_q <= 1'b0;
        rtog_q <= ~rtog_q;
      end else if (arr_pulse) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign full_n = full_n_q;
  assign data   = data_q;

endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_write,
  input  logic              a_mbox,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_fifo_wr,
  output logic              a_fifo_rd,
  output logic              a_mb1_full_n,
  input  logic              b_en,
  input  logic              b_write,
  input  logic              b_mbox,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_fifo_wr,
  output logic              b_fifo_rd,
  output logic              b_mb2_full_n
);
  import mbox_pkg::*;

  port_op_t          op_a;
  port_op_t          op_b;

  // Internal events, named for the bound checker.
  logic              m1_wr_acc;
  logic              m1_rel;
  logic [DATA_W-1:0] m1_data;
  logic              m2_wr_acc;
  logic              m2_rel;
  logic [DATA_W-1:0] m2_data;

  mbox_port_decode u_dec_a (.en(a_en), .wr(a_write), .mbx(a_mbox), .op(op_a));
  mbox_port_decode u_dec_b (.en(b_en), .wr(b_write), .mbx(b_mbox), .op(op_b));

  // Mailbox 1: written on port A, read on port B.
  mbox_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mb1 (
    .clk_w    (clk_a),
    .clk_r    (clk_b),
    .rst_n    (rst_n),
    .wr_req   (op_a.mbx_wr),
    .wdata    (a_wdata),
    .rd_req   (op_b.mbx_rd),
    .full_n   (a_mb1_full_n),
    .data     (m1_data),
    .wr_acc   (m1_wr_acc),
    .rel_pulse(m1_rel)
  );

  // Mailbox 2: written on port B, read on port A.
  mbox_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mb2 (
    .clk_w    (clk_b),
    .clk_r    (clk_a),
    .rst_n    (rst_n),
    .wr_req   (op_b.mbx_wr),
    .wdata    (b_wdata),
    .rd_req   (op_a.mbx_rd),
    .full_n   (b_mb2_full_n),
    .data     (m2_data),
    .wr_acc   (m2_wr_acc),
    .rel_pulse(m2_rel)
  );

  assign a_fifo_wr = op_a.fifo_wr;
  assign a_fifo_rd = op_a.fifo_rd;
  assign b_fifo_wr = op_b.fifo_wr;
  assign b_fifo_rd = op_b.fifo_rd;

  assign a_rdata = m2_data;
  assign b_rdata = b_mbox ? m1_data : fifo_rdata;

endmodule

// File: rtl/mailbox_pair_chk.sv
module mailbox_pair_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst_n,
  input logic              a_mb1_full_n,
  input logic              b_mb2_full_n,
  input logic              m1_wr_acc,
  input logic              m1_rel,
  input logic [DATA_W-1:0] m1_data,
  input logic              m2_wr_acc,
  input logic              m2_rel,
  input logic [DATA_W-1:0] m2_data
);

  // R2
  m1_write_locks_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    m1_wr_acc |=> !a_mb1_full_n);

  // R3
  m1_hold_while_full_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!a_mb1_full_n && !m1_rel) |=> (!a_mb1_full_n && $stable(m1_data)));

  // R4
  m1_release_needs_word_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    m1_rel |-> !a_mb1_full_n);

  // R4
  m1_rise_from_release_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    $rose(a_mb1_full_n) |-> $past(m1_rel));

  // R5
  m2_write_locks_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    m2_wr_acc |=> !b_mb2_full_n);

  // R5
  m2_hold_while_full_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!b_mb2_full_n && !m2_rel) |=> (!b_mb2_full_n && $stable(m2_data)));

  // R5
  m2_release_needs_word_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    m2_rel |-> !b_mb2_full_n);

  // R8
  m1_release_beats_write_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    (m1_rel && !a_mb1_full_n) |=> a_mb1_full_n);

endmodule

bind mailbox_pair mailbox_pair_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_a       (clk_a),
  .clk_b       (clk_b),
  .rst_n       (rst_n),
  .a_mb1_full_n(a_mb1_full_n),
  .b_mb2_full_n(b_mb2_full_n),
  .m1_wr_acc   (m1_wr_acc),
  .m1_rel      (m1_rel),
  .m1_data     (m1_data),
  .m2_wr_acc   (m2_wr_acc),
  .m2_rel      (m2_rel),
  .m2_data     (m2_data)
);

// File: tb/sim_mailbox_pair.sv
`timescale 1ns/1ps
module sim_mailbox_pair;
  localparam int W = 36;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n = 1'b0;
  logic a_en = 0, a_write = 0, a_mbox = 0;
  logic b_en = 0, b_write = 0, b_mbox = 0;
  logic [W-1:0] a_wdata = '0, b_wdata = '0, fifo_rdata = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic a_fifo_wr, a_fifo_rd, b_fifo_wr, b_fifo_rd, a_mb1_full_n, b_mb2_full_n;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] q1[$];
  logic [W-1:0] q2[$];

  always #4 clk_a = ~clk_a;      // 125 MHz
  always #5.5 clk_b = ~clk_b;    // unrelated port-B clock

  mailbox_pair #(.DATA_W(W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one port-A access of one clk_a cycle; returns at the next falling edge.
  task automatic a_op(input bit wr, input bit mbx, input logic [W-1:0] d);
    @(negedge clk_a);
    a_en = 1; a_write = wr; a_mbox = mbx; a_wdata = d;
    @(negedge clk_a);
    a_en = 0;
  endtask

  task automatic b_op(input bit wr, input bit mbx, input logic [W-1:0] d);
    @(negedge clk_b);
    b_en = 1; b_write = wr; b_mbox = mbx; b_wdata = d;
    @(negedge clk_b);
    b_en = 0;
  endtask

  // Mailbox 1 read on port B; the monitor pops the scoreboard and compares.
  task automatic b_mail_read(input string req);
    logic [W-1:0] exp;
    @(negedge clk_b);
    b_en = 1; b_write = 0; b_mbox = 1;
    #1;
    exp = (q1.size() > 0) ? q1.pop_front() : '0;
    chk(b_rdata === exp, req, b_rdata, exp);
    @(negedge clk_b);
    b_en = 0;
  endtask

  task automatic a_mail_read(input string req);
    logic [W-1:0] exp;
    @(negedge clk_a);
    a_en = 1; a_write = 0; a_mbox = 1;
    #1;
    exp = (q2.size() > 0) ? q2.pop_front() : '0;
    chk(a_rdata === exp, req, a_rdata, exp);
    @(negedge clk_a);
    a_en = 0;
  endtask

  task automatic wait_a_flag(input string req);
    bit seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk_a);
      if (a_mb1_full_n) seen = 1;
    end
    chk(seen, req, {35'b0, a_mb1_full_n}, 1);
  endtask

  task automatic wait_b_flag(input string req);
    bit seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk_b);
      if (b_mb2_full_n) seen = 1;
    end
    chk(seen, req, {35'b0, b_mb2_full_n}, 1);
  endtask

  task automatic idle_b(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_b);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] cap;
    int hi_cnt;
    repeat (3) @(negedge clk_a);
    rst_n = 1;
    repeat (2) @(negedge clk_a);

    // R6: reset state
    chk(a_mb1_full_n === 1'b1, "R6 mb1 flag", {35'b0, a_mb1_full_n}, 1);
    chk(b_mb2_full_n === 1'b1, "R6 mb2 flag", {35'b0, b_mb2_full_n}, 1);
    chk(a_rdata === '0, "R6 mb2 cleared", a_rdata, 0);

    // R7: port-B output multiplexer
    fifo_rdata = 36'h9_ABCD_1234; b_mbox = 0; #1;
    chk(b_rdata === fifo_rdata, "R7 fifo path", b_rdata, fifo_rdata);
    b_mbox = 1; #1;
    chk(b_rdata === '0, "R7 mailbox path", b_rdata, 0);

    // R1: decode, all within half a clk_a cycle
    @(negedge clk_a);
    a_en = 1; a_write = 1; a_mbox = 0; #1;
    chk({a_fifo_wr, a_fifo_rd} === 2'b10, "R1 A fifo write", {34'b0, a_fifo_wr, a_fifo_rd}, 2);
    a_write = 0; #1;
    chk({a_fifo_wr, a_fifo_rd} === 2'b01, "R1 A fifo read", {34'b0, a_fifo_wr, a_fifo_rd}, 1);
    a_mbox = 1; #1;
    chk({a_fifo_wr, a_fifo_rd} === 2'b00, "R1 A mailbox select", {34'b0, a_fifo_wr, a_fifo_rd}, 0);
    a_en = 0; a_mbox = 0; #1;
    chk({a_fifo_wr, a_fifo_rd} === 2'b00, "R1 A disabled", {34'b0, a_fifo_wr, a_fifo_rd}, 0);
    @(negedge clk_b);
    b_en = 1; b_write = 1; b_mbox = 0; #1;
    chk({b_fifo_wr, b_fifo_rd} === 2'b10, "R1 B fifo write", {34'b0, b_fifo_wr, b_fifo_rd}, 2);
    b_write = 0; #1;
    chk({b_fifo_wr, b_fifo_rd} === 2'b01, "R1 B fifo read", {34'b0, b_fifo_wr, b_fifo_rd}, 1);
    b_en = 0; b_mbox = 1;

    // R2: first write accepted
    a_op(1, 1, 36'h1_1111_0001); q1.push_back(36'h1_1111_0001);
    chk(a_mb1_full_n === 1'b0, "R2 flag low", {35'b0, a_mb1_full_n}, 0);
    // R3: second write refused
    a_op(1, 1, 36'h2_2222_0002);
    chk(a_mb1_full_n === 1'b0, "R3 flag stays low", {35'b0, a_mb1_full_n}, 0);
    #1 chk(b_rdata === 36'h1_1111_0001, "R3 word kept", b_rdata, 36'h1_1111_0001);

    // R4: release by port-B read
    idle_b(6);
    b_mail_read("R4 mailbox 1 read data");
    wait_a_flag("R4 flag raised");

    // R4: read with nothing pending is ignored
    b_op(0, 1, '0);
    b_mbox = 1;
    a_op(1, 1, 36'h3_3333_0003); q1.push_back(36'h3_3333_0003);
    repeat (14) @(negedge clk_a);
    chk(a_mb1_full_n === 1'b0, "R4 stale read ignored", {35'b0, a_mb1_full_n}, 0);
    b_mail_read("R4 second word");
    wait_a_flag("R4 flag raised again");

    // R5: mailbox 2
    b_op(1, 1, 36'h5_0505_0505); q2.push_back(36'h5_0505_0505);
    chk(b_mb2_full_n === 1'b0, "R5 flag low", {35'b0, b_mb2_full_n}, 0);
    b_op(1, 1, 36'h6_0606_0606);
    chk(b_mb2_full_n === 1'b0, "R5 write refused", {35'b0, b_mb2_full_n}, 0);
    b_write = 0; b_mbox = 1;
    repeat (6) @(negedge clk_a);
    chk(a_rdata === 36'h5_0505_0505, "R5 word kept", a_rdata, 36'h5_0505_0505);
    a_mail_read("R5 mailbox 2 read data");
    wait_b_flag("R5 flag raised");

    // R8: release meets a held write request
    a_op(1, 1, 36'h4_4444_0004); q1.push_back(36'h4_4444_0004);
    hi_cnt = 0; cap = '0;
    fork
      begin
        bit done = 0;
        for (int i = 0; i < 40 && !done; i++) begin
          @(negedge clk_a);
          if (a_mb1_full_n) hi_cnt++;
          else if (hi_cnt > 0) done = 1;
          a_en = 1; a_write = 1; a_mbox = 1;
          a_wdata = 36'hA_0000_0000 | 36'(i);
          if (a_mb1_full_n) cap = a_wdata;
        end
        a_en = 0;
      end
      begin
        idle_b(6);
        b_mail_read("R8 prior word");
      end
    join
    chk(hi_cnt == 1, "R8 flag high one cycle", 36'(hi_cnt), 1);
    chk(a_mb1_full_n === 1'b0, "R8 new word held", {35'b0, a_mb1_full_n}, 0);
    q1.push_back(cap);
    idle_b(6);
    b_mail_read("R8 word from following edge");
    wait_a_flag("R8 flag raised at end");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule